// File: doc/BRIEF.md
# Low-Order Interleaved Burst Reader

This block is a read front end over a word memory of 2^ADDR_W words that is split across 2^BANK_W independent word-wide banks. A word address is cut in two. The low BANK_W bits pick the bank, and the remaining high bits pick the row inside that bank. Consecutive addresses therefore fall in consecutive banks. One access reads the same row from every bank in parallel and returns a full group of adjacent words.

A requester starts a burst by presenting a start address and a length in words. The block reads the row that holds the start address from all banks at once. It captures the returned group in a set of output latches and then steps a multiplexer across the latches, so one word leaves per cycle. While a group drains, the block issues the read for the following row. The issue is timed so that the new group lands in the latches just as the last latched word leaves. With the default bank latency equal to the bank count, a sequential stream therefore runs gap-free.

A new request always wins. It throws away the latched group and any read still in flight, and starts a fresh bank access at the new address.

Top module: `ilv_burst_reader`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a request is accepted.
- R2: `req_ready` is held high. A request is accepted at every rising clock edge where `req_valid` is high.
- R3: The first word of an accepted non-empty burst is presented with `out_valid` high in the cycle after the (LAT+1)-th rising edge, counting the acceptance edge as the first. Its `out_addr` equals the start address.
- R4: Bank `a[BANK_W-1:0]`, row `a[ADDR_W-1:BANK_W]` holds the word at address `a`. Its value is (FILL_MUL·a + FILL_ADD) mod 2^DATA_W, which is 37·a + 1000 mod 65536 with the default parameters. Every presented word satisfies `out_data` = that value for a = `out_addr`.
- R5: Words of one burst are presented in strictly increasing address order. Each `out_addr` is the previous one plus one, modulo 2^ADDR_W, so address 255 is followed by address 0.
- R6: A burst of length L presents exactly L words. A request with L = 0 presents none.
- R7: With LAT equal to the bank count and a start address whose low BANK_W bits are zero, the L words of a burst appear in L consecutive cycles with no idle cycle between them.
- R8: With LAT equal to the bank count and a start offset o = start[BANK_W-1:0] other than zero, the first group delivers the words from offset o to the end of its row. Exactly o idle cycles then follow, and the rest of the burst runs with no idle cycle.
- R9: Accepting a request ends any burst in progress. `out_valid` is low in the cycle after the acceptance edge, and no word of the old burst is presented afterwards. This holds for a new request of length zero too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Request can be taken (held high) |
| req_addr | input | ADDR_W | Start word address of the burst |
| req_len | input | ADDR_W+1 | Burst length in words, 0 to 2^ADDR_W |
| out_valid | output | 1 | A burst word is presented this cycle |
| out_addr | output | ADDR_W | Address of the presented word |
| out_data | output | DATA_W | Presented word |

## Verification
The bench targets the seams between groups. It runs aligned, unaligned and wrapping starts, and it checks where each idle cycle falls as well as how many there are. A prefetch issued one cycle late would show up as an idle cycle in an aligned stream. A prefetch issued early would overwrite the latches before they had drained, so words would be skipped or repeated.

Aborts are exercised mid-stream, both with a non-empty replacement and with a zero-length one. A design that failed to flush the read pipeline would present a stale row once the old read landed. The zero-length and single-word bursts, and the full-memory burst that wraps from 255 to 0, catch length bookkeeping that is off by one group or that mishandles the row counter rolling over.

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader #(
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int LAT      = 2 ** BANK_W,
  parameter int FILL_MUL = 37,
  parameter int FILL_ADD = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ADDR_W:0]     req_len,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_data
);
  localparam int BANKS = 2 ** BANK_W;
  localparam int ROW_W = ADDR_W - BANK_W;
  localparam int ROWS  = 2 ** ROW_W;
  localparam int LEN_W = ADDR_W + 1;
  localparam int CNT_W = BANK_W + 1;
  localparam logic [LAT-1:0] LAST_STAGE = LAT'(1) << (LAT - 1);

  function automatic logic [DATA_W-1:0] fill(input logic [ADDR_W-1:0] a);
    return DATA_W'(int'(a) * FILL_MUL + FILL_ADD);
  endfunction

  logic [LAT-1:0]          vld;
  logic [ROW_W-1:0]        p_row [LAT];
  logic [BANK_W-1:0]       p_off [LAT];
  logic [CNT_W-1:0]        p_cnt [LAT];
  logic [BANKS*DATA_W-1:0] bank_out;
  logic [BANKS*DATA_W-1:0] lat_data;
  logic [ROW_W-1:0]        lat_row;
  logic [BANK_W-1:0]       lat_idx;
  logic [CNT_W-1:0]        lat_left;
  logic [ROW_W-1:0]        nxt_row;
  logic [LEN_W-1:0]        fetch_rem;

  logic              arrive, busy, pf_go, issue;
  logic [CNT_W-1:0]  left_after, room, iss_cnt;
  logic [ROW_W-1:0]  iss_row;
  logic [BANK_W-1:0] iss_off;
  logic [LEN_W-1:0]  want;

  assign req_ready  = 1'b1;
  assign out_valid  = lat_left != '0;
  assign out_addr   = {lat_row, lat_idx};
  assign out_data   = lat_data[lat_idx*DATA_W +: DATA_W];

  assign arrive     = vld[LAT-1];
  assign busy       = |(vld & ~LAST_STAGE);
  assign left_after = arrive ? p_cnt[LAT-1] : lat_left - CNT_W'(out_valid);
  assign pf_go      = !req_valid && fetch_rem != '0 && !busy && int'(left_after) <= LAT;
  assign issue      = req_valid ? (req_len != '0) : pf_go;
  assign iss_row    = req_valid ? req_addr[ADDR_W-1:BANK_W] : nxt_row;
  assign iss_off    = req_valid ? req_addr[BANK_W-1:0] : '0;
  assign room       = CNT_W'(BANKS) - CNT_W'(iss_off);
  assign want       = req_valid ? req_len : fetch_rem;
  assign iss_cnt    = (want < LEN_W'(room)) ? CNT_W'(want) : room;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem  [ROWS];
    logic [DATA_W-1:0] pipe [LAT];

    initial begin
      for (int r = 0; r < ROWS; r++) mem[r] = fill(ADDR_W'(r * BANKS + b));
    end

    always_ff @(posedge clk) begin
      if (issue) pipe[0] <= mem[iss_row];
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end

    assign bank_out[b*DATA_W +: DATA_W] = pipe[LAT-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      fetch_rem <= '0;
      nxt_row   <= '0;
      lat_row   <= '0;
      lat_idx   <= '0;
      lat_left  <= '0;
      for (int k = 0; k < LAT; k++) begin
        p_row[k] <= '0;
        p_off[k] <= '0;
        p_cnt[k] <= '0;
      end
    end else begin
      vld[0]   <= issue;
      p_row[0] <= iss_row;
      p_off[0] <= iss_off;
      p_cnt[0] <= iss_cnt;
      for (int k = 1; k < LAT; k++) begin
        vld[k]   <= req_valid ? 1'b0 : vld[k-1];
        p_row[k] <= p_row[k-1];
        p_off[k] <= p_off[k-1];
        p_cnt[k] <= p_cnt[k-1];
      end

      if (issue) begin
        fetch_rem <= want - LEN_W'(iss_cnt);
        nxt_row   <= iss_row + 1'b1;
      end else if (req_valid) begin
        fetch_rem <= '0;
      end

      if (req_valid) begin
        lat_left <= '0;
      end else if (arrive) begin
        lat_row  <= p_row[LAT-1];
        lat_idx  <= p_off[LAT-1];
        lat_left <= p_cnt[LAT-1];
      end else if (out_valid) begin
        lat_idx  <= lat_idx + 1'b1;
        lat_left <= lat_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!req_valid && arrive) lat_data <= bank_out;
  end
endmodule

// File: rtl/ilv_burst_reader_chk.sv
module ilv_burst_reader_chk #(
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int LAT      = 4,
  parameter int FILL_MUL = 37,
  parameter int FILL_ADD = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W:0]   req_len,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);
  localparam int BANKS = 2 ** BANK_W;

  logic          started, seen, aligned_q;
  int unsigned   since;
  logic [ADDR_W+1:0] outs, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      seen      <= 1'b0;
      aligned_q <= 1'b0;
      since     <= 0;
      outs      <= '0;
      len_q     <= '0;
    end else if (req_valid) begin
      started   <= 1'b1;
      seen      <= 1'b0;
      aligned_q <= req_addr[BANK_W-1:0] == '0;
      since     <= 1;
      outs      <= '0;
      len_q     <= (ADDR_W+2)'(req_len);
    end else begin
      if (since < LAT + 2) since <= since + 1;
      if (out_valid) begin
        seen <= 1'b1;
        outs <= outs + 1'b1;
      end
    end
  end

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !out_valid);

  p_first_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !seen |-> since == LAT + 1);

  p_content_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == DATA_W'(int'(out_addr) * FILL_MUL + FILL_ADD));

  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) && !$past(req_valid) |-> out_addr == $past(out_addr) + 1'b1);

  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> outs < len_q);

  p_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT == BANKS) && aligned_q && $fell(out_valid) && !$past(req_valid) |-> outs == len_q);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !out_valid);
endmodule

bind ilv_burst_reader ilv_burst_reader_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .LAT(LAT),
  .FILL_MUL(FILL_MUL), .FILL_ADD(FILL_ADD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_len(req_len), .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
);

// File: tb/tb_ilv_burst_reader.sv
module tb_ilv_burst_reader;
  localparam int LAT = 4;
  localparam int M   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [8:0]  req_len = '0;
  logic        out_valid;
  logic [7:0]  out_addr;
  logic [15:0] out_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ilv_burst_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data)
  );

  function automatic int exp_word(input int a);
    return (a * 37 + 1000) % 65536;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int a, input int l);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 8'(a);
    req_len   = 9'(l);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic observe(input int a, input int l, input int exp_gaps, input int exp_gap_at,
                         input string tag);
    int cnt = 0;
    int gaps = 0;
    int gap_at = -1;
    int first_k = -1;
    for (int k = 1; k <= l + LAT + 2 * M + 8; k++) begin
      @(negedge clk);
      if (out_valid) begin
        if (first_k < 0) begin
          first_k = k;
          check("R3", {tag, " first word cycle"}, k, LAT + 1);
        end
        check("R5", {tag, " address"}, int'(out_addr), (a + cnt) % 256);
        check("R4", {tag, " data"}, int'(out_data), exp_word((a + cnt) % 256));
        cnt++;
      end else if (cnt > 0 && cnt < l) begin
        if (gap_at < 0) gap_at = cnt;
        gaps++;
      end
    end
    check("R6", {tag, " word count"}, cnt, l);
    if (l > 0) begin
      if (exp_gaps == 0) check("R7", {tag, " idle cycles"}, gaps, 0);
      else begin
        check("R8", {tag, " idle cycles"}, gaps, exp_gaps);
        check("R8", {tag, " idle position"}, gap_at, exp_gap_at);
      end
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check("R1", "valid cycles after reset", seen, 0);
    check("R2", "ready level", int'(req_ready), 1);
  endtask

  task automatic t_aligned();
    issue(8'h10, 12);
    observe(8'h10, 12, 0, 0, "aligned");
  endtask

  task automatic t_unaligned();
    issue(8'h21, 10);
    observe(8'h21, 10, 1, 3, "unaligned");
  endtask

  task automatic t_wrap();
    issue(8'hFA, 10);
    observe(8'hFA, 10, 2, 2, "wrap");
  endtask

  task automatic t_short();
    issue(8'h07, 1);
    observe(8'h07, 1, 0, 0, "single");
    issue(8'h30, 0);
    observe(8'h30, 0, 0, 0, "empty");
  endtask

  task automatic t_abort();
    int seen = 0;
    issue(8'h40, 20);
    repeat (8) @(negedge clk);
    check("R9", "old burst running before abort", int'(out_valid), 1);
    issue(8'h83, 5);
    observe(8'h83, 5, 3, 1, "R9 abort");
    issue(8'h00, 30);
    repeat (7) @(negedge clk);
    issue(8'h10, 0);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check("R9", "words after zero-length abort", seen, 0);
  endtask

  task automatic t_full();
    issue(8'h00, 256);
    observe(8'h00, 256, 0, 0, "full memory");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    t_reset();
    t_aligned();
    t_unaligned();
    t_wrap();
    t_short();
    t_abort();
    t_full();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule